// File: doc/BRIEF.md
# System Configuration Registers with Interrupt-Line Port Selector

This block is a memory-mapped bank of eleven 32-bit configuration words, reached over a plain word-access bus. The bus has a byte address, a write strobe, write data and read data. Each bit has its own access policy. A bit can be freely writable, reserved (always reads zero), set-only, clear-only, or a hardware flag that software clears by writing 1. Reads are combinational. A write takes effect at the rising clock edge on which the strobe is sampled.

Four of the words hold 4-bit port-select fields, one field for each of 16 interrupt lines. The block routes one pin from a bank of 128 GPIO inputs onto each line. The inputs are organised as 8 ports of 16 pins. Line n carries pin n of the port named by its field. A downstream interrupt controller does the edge detection and masking. This block only stores bits and routes signals.

Top module: `sys_cfg_mux`

## Requirements
- R1: After reset, word 1 (byte offset 0x04) reads 0x7C000001 and every other word reads 0x00000000.
- R2: The word index is bus_addr[5:2]; bus_addr[1:0] are ignored. Indices 0 to 10 (offsets 0x00 to 0x28) are valid. Reads at index 11 or above return zero, and writes there change no register.
- R3: Only these bits are freely writable: word 0 bits 8 and 2:0; word 1 bits 31:26, 23:16 and 8; words 2 to 5 bits 15:0; word 9 bits 7:0. All other bits of these words read zero.
- R4: Word 1 bit 0 is clear-only. Writing 0 clears it. Writing 1 later leaves it 0 until reset.
- R5: Word 7 bits 3:0 are set-only. Writing 1 sets a bit and writing 0 has no effect.
- R6: Word 7 bit 8 is a flag. It becomes 1 on the edge that samples err_event high. Software writing 1 to it clears it, and such a write never sets it. If both happen on the same edge, the hardware set wins.
- R7: Every bit of words 8 and 10 is set-only and stays set until reset.
- R8: Word 6 (offset 0x18) always reads zero, and writes to it are ignored.
- R9: Line n's select field is bits 4*(n%4)+3:4*(n%4) of word 2+n/4. irq_line[n] equals gpio_in[sel*16+n] combinationally, so a pin of an unselected port has no effect on the line.
- R10: A select value of 8 or more holds the line low whatever the GPIO inputs are.
- R11: bus_rdata reflects a write only after the clock edge that samples it. Before that edge it still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| err_event | input | 1 | Hardware event that sets the word 7 bit 8 flag |
| gpio_in | input | 128 | GPIO inputs, index port*16+pin |
| irq_line | output | 16 | Routed interrupt lines |

## Verification
A register write becomes visible one clock edge after the strobe is presented, and the same holds for an err_event pulse. The bench therefore drives on the falling edge and reads back 1 ns after the following falling edge. Read data and the interrupt lines are combinational, so a GPIO change or an address change is checked 1 ns after it is applied, within the same half cycle. One directed check samples read data before the write edge to confirm the old value is still shown.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;
  localparam int NREG     = 11;
  localparam int DW       = 32;
  localparam int IDX_FLAG = 7;
  localparam int SEL_BASE = 2;

  localparam logic [DW-1:0] RST_VAL [NREG] = '{
    32'h0, 32'h7C000001, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [DW-1:0] RW_MSK [NREG] = '{
    32'h00000107, 32'hFCFF0100, 32'h0000FFFF, 32'h0000FFFF, 32'h0000FFFF,
    32'h0000FFFF, 32'h0, 32'h0, 32'h0, 32'h000000FF, 32'h0};
  localparam logic [DW-1:0] SO_MSK [NREG] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0000000F, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF};
  localparam logic [DW-1:0] CO_MSK [NREG] = '{
    32'h0, 32'h00000001, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [DW-1:0] W1C_MSK [NREG] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h00000100, 32'h0, 32'h0, 32'h0};
endpackage

// File: rtl/cfg_bit_reg.sv
module cfg_bit_reg #(
  parameter int          DW    = 32,
  parameter logic [DW-1:0] RST_V = '0,
  parameter logic [DW-1:0] RW_M  = '0,
  parameter logic [DW-1:0] SO_M  = '0,
  parameter logic [DW-1:0] CO_M  = '0,
  parameter logic [DW-1:0] W1C_M = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;
  logic [DW-1:0] wd;
  logic          upd;

  always_comb begin
    wd    = wr_en ? wdata : '0;
    q_nxt = (wr_en ? (wdata & RW_M) : (q & RW_M))
          | (SO_M  & (q | wd))
          | (CO_M  & q & (wr_en ? wdata : '1))
          | (W1C_M & ((q & ~wd) | hw_set));
    upd   = wr_en | (|(hw_set & W1C_M));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RST_V;
    else if (upd) q <= q_nxt;
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import sys_cfg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              err_event,
  output logic [DW-1:0]     bus_rdata,
  output logic [NREG*DW-1:0] reg_flat
);
  localparam int IW = ADDR_W - 2;
  logic [IW-1:0] idx;
  logic [DW-1:0] q [NREG];

  assign idx = bus_addr[ADDR_W-1:2];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          we_i;
    logic [DW-1:0] hs_i;
    assign we_i = bus_wr && (idx == IW'(i));
    if (i == IDX_FLAG) begin : g_hw
      assign hs_i = W1C_MSK[i] & {DW{err_event}};
    end else begin : g_nohw
      assign hs_i = '0;
    end
    cfg_bit_reg #(
      .DW(DW), .RST_V(RST_VAL[i]), .RW_M(RW_MSK[i]), .SO_M(SO_MSK[i]),
      .CO_M(CO_MSK[i]), .W1C_M(W1C_MSK[i])
    ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(we_i), .wdata(bus_wdata),
      .hw_set(hs_i), .q(q[i])
    );
    assign reg_flat[i*DW +: DW] = q[i];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == IW'(i)) bus_rdata = q[i];
  end
endmodule

// File: rtl/line_mux.sv
module line_mux #(
  parameter int N_PORTS = 8,
  parameter int N_LINES = 16,
  parameter int SEL_W   = 4
) (
  input  logic [N_LINES*SEL_W-1:0]   sel_flat,
  input  logic [N_PORTS*N_LINES-1:0] gpio_in,
  output logic [N_LINES-1:0]         irq_line
);
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    logic [SEL_W-1:0]   sel;
    logic [N_PORTS-1:0] col;
    assign sel = sel_flat[n*SEL_W +: SEL_W];
    for (genvar p = 0; p < N_PORTS; p++) begin : g_col
      assign col[p] = gpio_in[p*N_LINES + n];
    end
    always_comb begin
      if (int'(sel) < N_PORTS) irq_line[n] = col[sel[PW-1:0]];
      else                     irq_line[n] = 1'b0;
    end
  end
endmodule

// File: rtl/sys_cfg_mux.sv
module sys_cfg_mux
  import sys_cfg_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int N_PORTS = 8,
  parameter int N_LINES = 16,
  parameter int SEL_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic                       err_event,
  input  logic [N_PORTS*N_LINES-1:0] gpio_in,
  output logic [N_LINES-1:0]         irq_line
);
  localparam int FPR = DW / 2 / SEL_W;
  logic [NREG*DW-1:0]        reg_flat;
  logic [N_LINES*SEL_W-1:0]  sel_flat;

  cfg_regfile #(.ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .err_event(err_event), .bus_rdata(bus_rdata),
    .reg_flat(reg_flat)
  );

  for (genvar n = 0; n < N_LINES; n++) begin : g_sel
    assign sel_flat[n*SEL_W +: SEL_W] =
      reg_flat[(SEL_BASE + n/FPR)*DW + (n%FPR)*SEL_W +: SEL_W];
  end

  line_mux #(.N_PORTS(N_PORTS), .N_LINES(N_LINES), .SEL_W(SEL_W)) u_mux (
    .sel_flat(sel_flat), .gpio_in(gpio_in), .irq_line(irq_line)
  );
endmodule

// File: rtl/sys_cfg_mux_chk.sv
module sys_cfg_mux_chk #(
  parameter int ADDR_W  = 6,
  parameter int N_PORTS = 8,
  parameter int N_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata,
  input logic                 err_event,
  input logic [N_LINES-1:0]   irq_line,
  input logic [11*32-1:0]     reg_flat
);
  AST_CLR_ONLY_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_flat[32] |=> !reg_flat[32]); // R4
  AST_SET_ONLY_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_flat[7*32 +: 4] & $past(reg_flat[7*32 +: 4])) == $past(reg_flat[7*32 +: 4]))); // R5
  AST_FLAG_SET_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> reg_flat[7*32 + 8]); // R6
  AST_PROTECT1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_flat[8*32 +: 32] & $past(reg_flat[8*32 +: 32])) == $past(reg_flat[8*32 +: 32]))); // R7
  AST_PROTECT2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_flat[10*32 +: 32] & $past(reg_flat[10*32 +: 32])) == $past(reg_flat[10*32 +: 32]))); // R7
  AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr[ADDR_W-1:2]) >= 11) |-> (bus_rdata == 32'h0)); // R2
  AST_SRAM_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr[ADDR_W-1:2]) == 6) |-> (bus_rdata == 32'h0)); // R8
  AST_BAD_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_flat[2*32 +: 4]) >= N_PORTS) |-> !irq_line[0]); // R10
endmodule

bind sys_cfg_mux sys_cfg_mux_chk #(.ADDR_W(ADDR_W), .N_PORTS(N_PORTS), .N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .err_event(err_event), .irq_line(irq_line), .reg_flat(reg_flat)
);

// File: tb/sim_sys_cfg_mux.sv
module sim_sys_cfg_mux;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [5:0]   bus_addr;
  logic         bus_wr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic         err_event;
  logic [127:0] gpio_in;
  logic [15:0]  irq_line;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [11];

  always #10 clk = ~clk;

  sys_cfg_mux u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_event(err_event),
    .gpio_in(gpio_in), .irq_line(irq_line)
  );

  function automatic logic [31:0] nxt(int i, logic [31:0] q, logic [31:0] d);
    case (i)
      0:       return d & 32'h00000107;
      1:       return (d & 32'hFCFF0100) | {31'b0, q[0] & d[0]};
      2,3,4,5: return d & 32'h0000FFFF;
      7:       return ((q | d) & 32'h0000000F) | (q & ~d & 32'h00000100);
      8, 10:   return q | d;
      9:       return d & 32'h000000FF;
      default: return q & 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_irq(logic [127:0] g);
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      logic [3:0] s;
      s = mdl[2 + n/4][4*(n%4) +: 4];
      r[n] = (s < 4'd8) ? g[int'(s)*16 + n] : 1'b0;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    int i;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    i = int'(a[5:2]);
    if (i < 11) mdl[i] = nxt(i, mdl[i], d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, string req);
    int i;
    bus_addr = a;
    #1;
    i = int'(a[5:2]);
    chk(req, bus_rdata, (i < 11) ? mdl[i] : 32'h0);
  endtask

  task automatic irq_chk(logic [127:0] g, string req);
    gpio_in = g;
    #1;
    chk(req, {16'h0, irq_line}, {16'h0, exp_irq(g)});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    err_event = 1'b0; gpio_in = '0;
    for (int i = 0; i < 11; i++) mdl[i] = 32'h0;
    mdl[1] = 32'h7C000001;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    for (int i = 0; i < 11; i++) rd(6'(i*4), "R1");

    // R2 invalid offsets ignored, low address bits ignored
    wr(6'h2C, 32'hFFFFFFFF);
    wr(6'h3C, 32'hFFFFFFFF);
    rd(6'h2C, "R2"); rd(6'h30, "R2");
    for (int i = 0; i < 11; i++) rd(6'(i*4), "R2");
    wr(6'h27, 32'h000000C3);
    rd(6'h24, "R2");

    // R3 writable masks
    wr(6'h00, 32'hFFFFFFFF); rd(6'h00, "R3");
    wr(6'h04, 32'h7F00FEFF); rd(6'h04, "R3");
    wr(6'h04, 32'hFFFFFFFF); rd(6'h04, "R3");
    wr(6'h08, 32'hFFFF0000); rd(6'h08, "R3");

    // R8 word 6 reads zero
    wr(6'h18, 32'hFFFFFFFF); rd(6'h18, "R8");

    // R5 set-only nibble
    wr(6'h1C, 32'h0000000F); wr(6'h1C, 32'h0); rd(6'h1C, "R5");

    // R6 flag behaviour
    wr(6'h1C, 32'h00000100); rd(6'h1C, "R6");
    @(negedge clk) err_event = 1'b1;
    @(posedge clk) mdl[7] = mdl[7] | 32'h100;
    @(negedge clk) err_event = 1'b0;
    rd(6'h1C, "R6");
    wr(6'h1C, 32'h00000100); rd(6'h1C, "R6");

    // R7 sticky protect words
    wr(6'h20, 32'h000000A5); wr(6'h20, 32'h0); rd(6'h20, "R7");
    wr(6'h20, 32'hFFFF0000); rd(6'h20, "R7");
    wr(6'h28, 32'h80000001); wr(6'h28, 32'h0); rd(6'h28, "R7");

    // R11 old value before the edge, new after
    @(negedge clk);
    bus_addr = 6'h24; bus_wdata = 32'h0000005A; bus_wr = 1'b1;
    #1 chk("R11", bus_rdata, mdl[9]);
    @(posedge clk) mdl[9] = nxt(9, mdl[9], 32'h5A);
    @(negedge clk) bus_wr = 1'b0;
    rd(6'h24, "R11");

    // R9 directed routing
    wr(6'h08, 32'h00000010);
    irq_chk(128'h1 << 17, "R9");
    chk("R9", {31'h0, irq_line[1]}, 32'h1);
    irq_chk(128'h1 << 1, "R9");
    chk("R9", {31'h0, irq_line[1]}, 32'h0);
    wr(6'h08, 32'h00000001);
    irq_chk(128'h1, "R9");
    chk("R9", {31'h0, irq_line[0]}, 32'h0);
    irq_chk(128'h1 << 16, "R9");
    chk("R9", {31'h0, irq_line[0]}, 32'h1);
    wr(6'h14, 32'h00007000);
    irq_chk(128'h1 << 127, "R9");
    chk("R9", {31'h0, irq_line[15]}, 32'h1);

    // R10 out-of-range select
    wr(6'h08, 32'h0000000F);
    irq_chk({128{1'b1}}, "R10");
    chk("R10", {31'h0, irq_line[0]}, 32'h0);
    wr(6'h08, 32'h00000008);
    irq_chk({128{1'b1}}, "R10");

    // R4 clear-only bit
    wr(6'h04, 32'h0); rd(6'h04, "R4");
    wr(6'h04, 32'h1); rd(6'h04, "R4");

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [5:0] a;
      a = 6'($urandom_range(0, 63));
      if (a[5:2] == 4'd8 || a[5:2] == 4'd10) a[5:2] = 4'd9;
      wr(a, $urandom());
      rd(6'($urandom_range(0, 63)), "R3");
      irq_chk({$urandom(), $urandom(), $urandom(), $urandom()}, "R9");
    end

    summary();
    $finish;
  end
endmodule